// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block is a blocking data cache between a 32-bit processor and a line-wide memory port. The processor uses word addresses. The cache stores eight lines of sixteen 32-bit words each, for 512 bytes in total. Each line has a tag, a valid flag and a modified flag. One line slot is selected by the index field of the request. A request hits when that slot is valid and its stored tag equals the request tag.

Writes change only the cached copy. A write miss first loads the line and then merges the word into it. Memory sees a line only when a modified line has to make room for another. In that case the whole old line goes out to memory before the new line is read in.

The processor raises `cpu_req` and holds address, strobe and write data steady until `cpu_ready` pulses for one cycle. The memory side carries one whole line per transfer. `mem_req` stays high, with stable address, direction and data, until `mem_ack` pulses.

Top module: `wb_dm_cache`

## Requirements
- R1: A 30-bit word address splits into tag = bits 29..7, index = bits 6..4 and word offset = bits 3..0. The memory line address is bits 29..4, and word w of a line sits at memory word address {line address, w}.
- R2: Reset clears every valid and modified flag. `cpu_ready` and `mem_req` are low during reset, and the first access to each index misses.
- R3: A read hit raises `cpu_ready` with the addressed word on `cpu_rdata` exactly one cycle after the request is first seen, with no memory transfer.
- R4: A write hit updates only the cached word, produces no memory transfer, and is returned by later reads.
- R5: A read miss to a slot that is invalid or unmodified issues exactly one line read at the request's line address. It then answers with the memory word.
- R6: A write miss loads the whole line from memory before merging the write word. The other words of the line keep their memory values.
- R7: A miss to a modified slot first writes the complete old line, including every write it received, to {stored tag, index}. Only then is the refill read issued.
- R8: A miss to a valid, unmodified slot performs no write-back.
- R9: A refill leaves the line unmodified, so a line that has only been read after its refill is later evicted without a write-back.
- R10: The cache is blocking. While a miss is being served, `cpu_ready` stays low, and `mem_req`, `mem_addr`, `mem_we` and `mem_wline` stay stable until `mem_ack`.
- R11: `cpu_ready` is a single-cycle pulse and appears only for a request that was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 30 | Word address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read word, valid with `cpu_ready` on reads |
| mem_req | output | 1 | Line transfer request, held until `mem_ack` |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 26 | Line address |
| mem_wline | output | 512 | Line being written back, word 0 in the low bits |
| mem_rline | input | 512 | Line returned by memory, sampled with `mem_ack` |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
The bench targets the following faults:
- **Eviction of a modified line.** Each written-back word is compared with the last value the processor wrote. A cache that lost a merged write, or that refilled before writing back, would return stale data on a later reread.
- **Write-back decision after a refill.** A slot that was refilled and only read must leave without a write-back. A cache that leaves the modified flag set after a refill would produce spurious writes.
- **Address fields at the edges.** All-ones tags, index 7 and offset 15 are used. A cache that swaps or truncates a field would send lines to the wrong memory address.
- **Hit latency and repeats.** Hit latency is counted in cycles. After each completion the bench checks that `cpu_ready` drops, which catches a cache that serves a request twice.

// File: rtl/wbc_pkg.sv
// Package: shared controller state encoding for the write-back cache.
// Assumes: nothing beyond being compiled before the modules that import it.
package wbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESP   = 2'd1,
        ST_EVICT  = 2'd2,
        ST_REFILL = 2'd3
    } ctrl_state_t;

endpackage

// File: rtl/wbc_tag_store.sv
// Tag, valid and modified-flag storage for a direct-mapped cache.
// Looks up one slot per cycle by index. Reports hit, the slot's modified
// state and its stored tag. A fill installs a tag as valid and unmodified.
// Assumes fill_en and mark_dirty are never high together.
module wbc_tag_store #(
    parameter int TAG_W = 23,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             mark_dirty,
    input  logic             fill_en,
    output logic             hit,
    output logic             victim_dirty,
    output logic [TAG_W-1:0] victim_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_vec;
    logic [LINES-1:0] dirty_vec;

    // Per-slot valid and modified flags.
    for (genvar i = 0; i < LINES; i++) begin : g_slot
        logic v_q;
        logic d_q;
        logic sel;
        assign sel = (lk_idx == IDX_W'(i));

        // Reset clears both flags, fill sets valid and clears modified, a write marks modified.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end else if (fill_en && sel) begin
                v_q <= 1'b1;
                d_q <= 1'b0;
            end else if (mark_dirty && sel) begin
                d_q <= 1'b1;
            end
        end

        assign valid_vec[i] = v_q;
        assign dirty_vec[i] = d_q;
    end

    // Tag storage is written only on a fill and needs no reset.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[lk_idx] <= lk_tag;
        end
    end

    assign hit          = valid_vec[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign victim_dirty = valid_vec[lk_idx] && dirty_vec[lk_idx];
    assign victim_tag   = tag_q[lk_idx];

endmodule

// File: rtl/wbc_data_store.sv
// Data array of a direct-mapped cache, one line per index.
// Supports a whole-line write for refills, a single-word write for store
// hits, a registered word read for load hits and a combinational whole-line
// read for write-backs. Assumes line_we and word_we are never high together.
module wbc_data_store #(
    parameter int WORD_W = 32,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [OFF_W-1:0]                  off,
    input  logic                              word_we,
    input  logic [WORD_W-1:0]                 word_in,
    input  logic                              rd_en,
    input  logic                              line_we,
    input  logic [WORD_W*(1<<OFF_W)-1:0]      line_in,
    output logic [WORD_W*(1<<OFF_W)-1:0]      line_out,
    output logic [WORD_W-1:0]                 word_out
);
    localparam int WORDS = 1 << OFF_W;
    localparam int LINES = 1 << IDX_W;

    logic [WORD_W-1:0] arr_q [LINES][WORDS];
    logic [WORD_W-1:0] word_q;

    // Array update: a refill replaces the line, a store hit replaces one word.
    always_ff @(posedge clk) begin
        if (line_we) begin
            for (int w = 0; w < WORDS; w++) begin
                arr_q[idx][w] <= line_in[w*WORD_W +: WORD_W];
            end
        end else if (word_we) begin
            arr_q[idx][off] <= word_in;
        end
    end

    // Read register: captures the addressed word on a load hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (rd_en) begin
            word_q <= arr_q[idx][off];
        end
    end

    // Flatten the selected line for write-back.
    for (genvar w = 0; w < WORDS; w++) begin : g_flat
        assign line_out[w*WORD_W +: WORD_W] = arr_q[idx][w];
    end

    assign word_out = word_q;

endmodule

// File: rtl/wbc_ctrl.sv
// Blocking controller for the write-back cache.
// A hit moves to a one-cycle response state. A miss to a modified slot
// first writes the old line back, then refills. After a refill the held
// request is looked up again and completes as a hit.
// Assumes the processor holds its request steady until the ready pulse.
module wbc_ctrl
    import wbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic        hit,
    input  logic        victim_dirty,
    input  logic        mem_ack,
    output ctrl_state_t state,
    output logic        ready,
    output logic        word_we,
    output logic        rd_en,
    output logic        mark_dirty,
    output logic        fill_en,
    output logic        mem_req,
    output logic        mem_we
);
    ctrl_state_t state_q;
    ctrl_state_t state_d;
    logic        hit_go;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (hit)               state_d = ST_RESP;
                    else if (victim_dirty) state_d = ST_EVICT;
                    else                   state_d = ST_REFILL;
                end
            end
            ST_RESP:   state_d = ST_IDLE;
            ST_EVICT:  if (mem_ack) state_d = ST_REFILL;
            ST_REFILL: if (mem_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign hit_go     = (state_q == ST_IDLE) && req && hit;
    assign word_we    = hit_go && we;
    assign mark_dirty = hit_go && we;
    assign rd_en      = hit_go && !we;
    assign fill_en    = (state_q == ST_REFILL) && mem_ack;
    assign ready      = (state_q == ST_RESP);
    assign mem_req    = (state_q == ST_EVICT) || (state_q == ST_REFILL);
    assign mem_we     = (state_q == ST_EVICT);
    assign state      = state_q;

endmodule

// File: rtl/wb_dm_cache.sv
// Top of the write-back, write-allocate, direct-mapped data cache.
// Splits the word address into tag, index and offset fields, connects the
// tag store, data store and controller, and forms the memory line address.
// Assumes one outstanding processor request and one outstanding line transfer.
module wb_dm_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [WORD_W-1:0]             cpu_wdata,
    output logic                          cpu_ready,
    output logic [WORD_W-1:0]             cpu_rdata,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-OFF_W-1:0]       mem_addr,
    output logic [WORD_W*(1<<OFF_W)-1:0]  mem_wline,
    input  logic [WORD_W*(1<<OFF_W)-1:0]  mem_rline,
    input  logic                          mem_ack
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [TAG_W-1:0] req_tag;
    logic [IDX_W-1:0] req_idx;
    logic [OFF_W-1:0] req_off;
    logic             hit;
    logic             victim_dirty;
    logic [TAG_W-1:0] victim_tag;
    logic             word_we;
    logic             rd_en;
    logic             mark_dirty;
    logic             fill_en;
    ctrl_state_t      state;

    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = cpu_addr[OFF_W +: IDX_W];
    assign req_off = cpu_addr[OFF_W-1:0];

    wbc_tag_store #(
        .TAG_W(TAG_W),
        .IDX_W(IDX_W)
    ) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_idx      (req_idx),
        .lk_tag      (req_tag),
        .mark_dirty  (mark_dirty),
        .fill_en     (fill_en),
        .hit         (hit),
        .victim_dirty(victim_dirty),
        .victim_tag  (victim_tag)
    );

    wbc_data_store #(
        .WORD_W(WORD_W),
        .OFF_W (OFF_W),
        .IDX_W (IDX_W)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (req_idx),
        .off     (req_off),
        .word_we (word_we),
        .word_in (cpu_wdata),
        .rd_en   (rd_en),
        .line_we (fill_en),
        .line_in (mem_rline),
        .line_out(mem_wline),
        .word_out(cpu_rdata)
    );

    wbc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (cpu_req),
        .we          (cpu_we),
        .hit         (hit),
        .victim_dirty(victim_dirty),
        .mem_ack     (mem_ack),
        .state       (state),
        .ready       (cpu_ready),
        .word_we     (word_we),
        .rd_en       (rd_en),
        .mark_dirty  (mark_dirty),
        .fill_en     (fill_en),
        .mem_req     (mem_req),
        .mem_we      (mem_we)
    );

    // Line address: the stored tag while writing back, the request tag while refilling.
    always_comb begin
        if (state == ST_EVICT) mem_addr = {victim_tag, req_idx};
        else                   mem_addr = {req_tag, req_idx};
    end

endmodule

// File: rtl/wbc_checker.sv
// Protocol checker for wb_dm_cache, attached to every instance by bind.
// Watches only the block's ports. Assumes the synchronous active-low reset.
module wbc_checker #(
    parameter int MA_W   = 26,
    parameter int LINE_W = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [MA_W-1:0]   mem_addr,
    input logic [LINE_W-1:0] mem_wline
);
    assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_ready_has_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> $past(cpu_req));

    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_wline_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> $stable(mem_wline));

    assert_refill_follows_evict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    assert_refill_then_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> !mem_req);

    assert_no_traffic_on_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

endmodule

bind wb_dm_cache wbc_checker #(
    .MA_W  (ADDR_W - OFF_W),
    .LINE_W(WORD_W * (1 << OFF_W))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wline(mem_wline)
);

// File: tb/wb_dm_cache_tb.sv
`timescale 1ns/1ps
module wb_dm_cache_tb;
    localparam int AW = 30;
    localparam int DW = 32;
    localparam int MW = 26;
    localparam int LW = 512;

    logic          clk;
    logic          rst_n;
    logic          cpu_req;
    logic          cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [MW-1:0] mem_addr;
    logic [LW-1:0] mem_wline;
    logic [LW-1:0] mem_rline;
    logic          mem_ack;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [MW-1:0] last_rd;
    logic [MW-1:0] last_wr;

    // Bench model of the cache state and of the processor-visible memory.
    logic        ev [8];
    logic        ed [8];
    logic [22:0] et [8];
    logic [31:0] mem_q  [logic [29:0]];
    logic [31:0] arch_q [logic [29:0]];

    initial clk = 1'b0;
    always #10 clk = ~clk;

    wb_dm_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wline(mem_wline), .mem_rline(mem_rline),
        .mem_ack(mem_ack)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] seed_word(input logic [29:0] a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] exp_word(input logic [29:0] a);
        return arch_q.exists(a) ? arch_q[a] : seed_word(a);
    endfunction

    function automatic logic [31:0] mem_word(input logic [29:0] a);
        return mem_q.exists(a) ? mem_q[a] : seed_word(a);
    endfunction

    // Behavioural line memory with a random response delay.
    initial begin
        int lat;
        logic [MW-1:0] la;
        logic [29:0] wa;
        mem_ack = 1'b0;
        mem_rline = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                lat = int'($urandom % 3);
                repeat (lat) @(negedge clk);
                la = mem_addr;
                if (mem_we) begin
                    wr_cnt++;
                    last_wr = la;
                    for (int w = 0; w < 16; w++) begin
                        wa = {la, 4'(w)};
                        check(mem_wline[w*32 +: 32] == exp_word(wa), "R7 written-back word",
                              64'(mem_wline[w*32 +: 32]), 64'(exp_word(wa)));
                        mem_q[wa] = mem_wline[w*32 +: 32];
                    end
                end else begin
                    rd_cnt++;
                    last_rd = la;
                    for (int w = 0; w < 16; w++) begin
                        wa = {la, 4'(w)};
                        mem_rline[w*32 +: 32] = mem_word(wa);
                    end
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // One processor access, checked against the bench model.
    task automatic access(input logic we, input logic [29:0] a, input logic [31:0] wd);
        logic [2:0]  idx;
        logic [22:0] tg;
        bit          exp_hit;
        bit          exp_wb;
        logic [MW-1:0] old_line;
        logic [31:0] exp_rd;
        int rd0, wr0, n;
        string lbl;
        idx = a[6:4];
        tg = a[29:7];
        exp_hit = ev[idx] && (et[idx] == tg);
        exp_wb = !exp_hit && ev[idx] && ed[idx];
        old_line = {et[idx], idx};
        exp_rd = exp_word(a);
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = a;
        cpu_wdata = wd;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ready && n < 200);
        check(cpu_ready == 1'b1, "R10 access completes", 64'(cpu_ready), 64'd1);
        if (exp_hit) begin
            lbl = we ? "R4" : "R3";
            check(n == 1, {lbl, " hit latency"}, 64'(n), 64'd1);
            check((rd_cnt == rd0) && (wr_cnt == wr0), {lbl, " hit causes no memory transfer"},
                  64'(rd_cnt - rd0 + wr_cnt - wr0), 64'd0);
        end else begin
            lbl = !ev[idx] ? "R2" : (exp_wb ? "R7" : (we ? "R6" : "R8"));
            check(rd_cnt - rd0 == 1, {lbl, " one refill read"}, 64'(rd_cnt - rd0), 64'd1);
            check(last_rd == a[29:4], "R1 refill line address", 64'(last_rd), 64'(a[29:4]));
            check(wr_cnt - wr0 == int'(exp_wb), {lbl, " R9 write-back count"},
                  64'(wr_cnt - wr0), 64'(exp_wb));
            if (exp_wb)
                check(last_wr == old_line, "R7 write-back address", 64'(last_wr), 64'(old_line));
        end
        if (!we)
            check(cpu_rdata == exp_rd, "R5 read data", 64'(cpu_rdata), 64'(exp_rd));
        cpu_req = 1'b0;
        @(negedge clk);
        check(cpu_ready == 1'b0, "R11 ready is one pulse", 64'(cpu_ready), 64'd0);
        if (!exp_hit) begin
            ev[idx] = 1'b1;
            et[idx] = tg;
            ed[idx] = 1'b0;
        end
        if (we) begin
            ed[idx] = 1'b1;
            arch_q[a] = wd;
        end
    endtask

    function automatic logic [29:0] mk(input logic [22:0] t, input logic [2:0] i, input logic [3:0] o);
        return {t, i, o};
    endfunction

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) begin
            ev[i] = 1'b0;
            ed[i] = 1'b0;
            et[i] = '0;
        end
        rst_n = 1'b0;
        cpu_req = 1'b0;
        cpu_we = 1'b0;
        cpu_addr = '0;
        cpu_wdata = '0;
        repeat (4) @(negedge clk);
        check(cpu_ready == 1'b0, "R2 ready low in reset", 64'(cpu_ready), 64'd0);
        check(mem_req == 1'b0, "R2 mem_req low in reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: first touch of every index misses; then R3 hits.
        for (int i = 0; i < 8; i++) access(1'b0, mk(23'd0, 3'(i), 4'(i)), '0);
        for (int i = 0; i < 8; i++) access(1'b0, mk(23'd0, 3'(i), 4'(15 - i)), '0);
        // R4: write hit, then read it back.
        access(1'b1, mk(23'd0, 3'd0, 4'd5), 32'hDEAD_BEEF);
        access(1'b0, mk(23'd0, 3'd0, 4'd5), '0);
        // R6: write miss to a clean slot, then neighbour word and written word.
        access(1'b1, mk(23'd5, 3'd1, 4'd2), 32'h1234_5678);
        access(1'b0, mk(23'd5, 3'd1, 4'd3), '0);
        access(1'b0, mk(23'd5, 3'd1, 4'd2), '0);
        // R7: evict the modified line, then reread it from memory.
        access(1'b0, mk(23'd9, 3'd1, 4'd0), '0);
        access(1'b0, mk(23'd5, 3'd1, 4'd2), '0);
        // R9 and R8: a read-only line leaves without write-back.
        access(1'b0, mk(23'd7, 3'd2, 4'd1), '0);
        access(1'b0, mk(23'd0, 3'd2, 4'd1), '0);
        // R1: extreme field values.
        access(1'b1, mk(23'h7F_FFFF, 3'd7, 4'd15), 32'hCAFE_F00D);
        access(1'b0, mk(23'h7F_FFFF, 3'd7, 4'd15), '0);
        access(1'b0, mk(23'd0, 3'd7, 4'd0), '0);
        access(1'b0, mk(23'h7F_FFFF, 3'd7, 4'd15), '0);

        // Random mix over a small tag pool to force conflicts.
        for (int k = 0; k < 600; k++) begin
            logic [22:0] t;
            int s;
            s = int'($urandom % 4);
            t = (s == 3) ? 23'h7F_FFFF : 23'(s);
            access(($urandom % 10) < 4, mk(t, 3'($urandom), 4'($urandom)), $urandom);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule